// File: doc/BRIEF.md
# Bus Error Capture and Timeout Unit

This block watches a shared single-outstanding address/data bus and records the first faulty transaction it sees. A fault has one of three causes. The addressed slave may answer with an error acknowledge. No slave may claim the address in the address phase. Or a claimed transaction may get no ready and no error acknowledge within a programmable number of bus clock cycles.

On the first fault, the unit stores the failing transaction in capture registers: its 32-bit address, direction, master number, the data bus value in the fault cycle, and a code for the cause. It sets a valid flag and, if enabled, pulses a service request. While the valid flag is set, the stored values stay frozen and any further faults only set an overflow flag. Software reads the capture and then pulses the clear input.

Top module: `bus_err_capture`

## Requirements
- R1: After reset the valid flag, overflow flag, service request, cause code and all captured fields are zero.
- R2: An error acknowledge that ends a claimed transaction causes a capture with cause code 1, and the valid flag is high from the following cycle.
- R3: An address phase (start high) with the claim input low causes a capture with cause code 2, using the address, direction and master number presented in that same cycle.
- R4: With timeout value N > 0, a claimed transaction that sees neither ready nor error acknowledge in the N cycles after its address phase is captured with cause code 3 at the end of the Nth cycle. Ready or error acknowledge in any of those N cycles ends the transaction.
- R5: A timeout value of zero disables timeout detection, so a transaction may wait indefinitely without a capture.
- R6: A capture stores the address, direction and master number from the failing transaction's address phase, and the data input from the cycle in which the fault is detected.
- R7: While the valid flag is set and no clear is given, a new fault leaves every captured field unchanged and sets the overflow flag.
- R8: A clear pulse drops the valid and overflow flags on the next edge. A fault in the same cycle as the clear is captured as a fresh first fault.
- R9: The service request is a one-cycle pulse in the cycle after a capture. It occurs only when the interrupt enable was high in the capture cycle.
- R10: When two faults arise in the same cycle with the valid flag clear, the one captured is chosen in priority order slave error, then timeout, then unclaimed address, and the overflow flag is set with it.
- R11: A claimed transaction ended by ready causes no capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Address phase of a transaction |
| addr_i | input | AW (32) | Transaction address |
| data_i | input | DW (32) | Data bus |
| we_i | input | 1 | 1 = write, 0 = read |
| mid_i | input | MW (4) | Master number |
| hit_i | input | 1 | Some slave claims the address (valid with start_i) |
| ready_i | input | 1 | Slave completes the transaction |
| err_ack_i | input | 1 | Slave answers with an error |
| tout_i | input | TW (16) | Timeout limit in cycles, 0 = off |
| irq_en_i | input | 1 | Service request enable |
| clear_i | input | 1 | Clears valid and overflow |
| cap_addr_o | output | AW | Captured address |
| cap_data_o | output | DW | Captured data |
| cap_we_o | output | 1 | Captured direction |
| cap_mid_o | output | MW | Captured master number |
| cap_kind_o | output | 2 | Cause: 1 slave error, 2 unclaimed, 3 timeout |
| cap_valid_o | output | 1 | Capture holds a fault |
| cap_ovf_o | output | 1 | More faults occurred after the capture |
| irq_o | output | 1 | Service request pulse |

## Verification
Each fault is detected combinationally in the cycle that the bus shows it, and it is registered at the next edge. So every captured field, both flags and the service request are due exactly one cycle after the fault cycle. For a timeout, that is one cycle after the Nth waiting cycle. The bench updates its reference at the same edge as the design and compares all outputs at the following falling edge. Directed checks sample the valid flag one cycle before and at the due cycle, which proves the timeout fires neither early nor late.

// File: rtl/bec_pkg.sv
package bec_pkg;
  typedef enum logic [1:0] {
    KIND_NONE      = 2'd0,
    KIND_SLAVE     = 2'd1,
    KIND_UNCLAIMED = 2'd2,
    KIND_TIMEOUT   = 2'd3
  } err_kind_e;
endpackage

// File: rtl/bec_tracker.sv
module bec_tracker #(
  parameter int AW = 32,
  parameter int MW = 4,
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          hit_i,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [MW-1:0] mid_i,
  input  logic          ready_i,
  input  logic          err_ack_i,
  input  logic [TW-1:0] tout_i,
  output logic          slv_evt_o,
  output logic          to_evt_o,
  output logic [AW-1:0] fl_addr_o,
  output logic          fl_we_o,
  output logic [MW-1:0] fl_mid_o
);
  localparam logic [TW-1:0] CntMax = '1;

  logic          busy_q;
  logic [TW-1:0] cnt_q;
  logic          at_limit;

  assign at_limit  = ((TW+1)'(cnt_q) + (TW+1)'(1)) == (TW+1)'(tout_i);
  assign slv_evt_o = busy_q && err_ack_i;
  assign to_evt_o  = busy_q && !ready_i && !err_ack_i && (tout_i != '0) && at_limit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      cnt_q     <= '0;
      fl_addr_o <= '0;
      fl_we_o   <= 1'b0;
      fl_mid_o  <= '0;
    end else if (start_i && hit_i) begin
      // new address phase replaces any outstanding one
      busy_q    <= 1'b1;
      cnt_q     <= '0;
      fl_addr_o <= addr_i;
      fl_we_o   <= we_i;
      fl_mid_o  <= mid_i;
    end else if (busy_q && (ready_i || err_ack_i || to_evt_o)) begin
      busy_q <= 1'b0;
    end else if (busy_q && cnt_q != CntMax) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/bec_classify.sv
module bec_classify #(
  parameter int AW = 32,
  parameter int MW = 4
) (
  input  logic               slv_evt_i,
  input  logic               to_evt_i,
  input  logic               unc_evt_i,
  input  logic [AW-1:0]      fl_addr_i,
  input  logic               fl_we_i,
  input  logic [MW-1:0]      fl_mid_i,
  input  logic [AW-1:0]      addr_i,
  input  logic               we_i,
  input  logic [MW-1:0]      mid_i,
  output logic               any_o,
  output logic               multi_o,
  output bec_pkg::err_kind_e kind_o,
  output logic [AW-1:0]      addr_o,
  output logic               we_o,
  output logic [MW-1:0]      mid_o
);
  import bec_pkg::*;

  logic [1:0] n_err;
  assign n_err   = 2'(slv_evt_i) + 2'(to_evt_i) + 2'(unc_evt_i);
  assign any_o   = n_err != 2'd0;
  assign multi_o = n_err > 2'd1;

  always_comb begin
    kind_o = KIND_NONE;
    addr_o = fl_addr_i;
    we_o   = fl_we_i;
    mid_o  = fl_mid_i;
    if (slv_evt_i) begin
      kind_o = KIND_SLAVE;
    end else if (to_evt_i) begin
      kind_o = KIND_TIMEOUT;
    end else if (unc_evt_i) begin
      kind_o = KIND_UNCLAIMED;
      addr_o = addr_i;
      we_o   = we_i;
      mid_o  = mid_i;
    end
  end
endmodule

// File: rtl/bec_capture.sv
module bec_capture #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int MW = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               any_i,
  input  logic               multi_i,
  input  bec_pkg::err_kind_e kind_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [DW-1:0]      data_i,
  input  logic               we_i,
  input  logic [MW-1:0]      mid_i,
  input  logic               irq_en_i,
  input  logic               clear_i,
  output logic [AW-1:0]      cap_addr_o,
  output logic [DW-1:0]      cap_data_o,
  output logic               cap_we_o,
  output logic [MW-1:0]      cap_mid_o,
  output logic [1:0]         cap_kind_o,
  output logic               cap_valid_o,
  output logic               cap_ovf_o,
  output logic               irq_o
);
  logic held;
  assign held = cap_valid_o && !clear_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_addr_o  <= '0;
      cap_data_o  <= '0;
      cap_we_o    <= 1'b0;
      cap_mid_o   <= '0;
      cap_kind_o  <= '0;
      cap_valid_o <= 1'b0;
      cap_ovf_o   <= 1'b0;
      irq_o       <= 1'b0;
    end else begin
      irq_o <= 1'b0;
      if (any_i && !held) begin
        cap_addr_o  <= addr_i;
        cap_data_o  <= data_i;
        cap_we_o    <= we_i;
        cap_mid_o   <= mid_i;
        cap_kind_o  <= kind_i;
        cap_valid_o <= 1'b1;
        cap_ovf_o   <= multi_i;
        irq_o       <= irq_en_i;
      end else if (clear_i) begin
        cap_valid_o <= 1'b0;
        cap_ovf_o   <= 1'b0;
      end else if (any_i) begin
        cap_ovf_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bus_err_capture.sv
module bus_err_capture #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int MW = 4,
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          we_i,
  input  logic [MW-1:0] mid_i,
  input  logic          hit_i,
  input  logic          ready_i,
  input  logic          err_ack_i,
  input  logic [TW-1:0] tout_i,
  input  logic          irq_en_i,
  input  logic          clear_i,
  output logic [AW-1:0] cap_addr_o,
  output logic [DW-1:0] cap_data_o,
  output logic          cap_we_o,
  output logic [MW-1:0] cap_mid_o,
  output logic [1:0]    cap_kind_o,
  output logic          cap_valid_o,
  output logic          cap_ovf_o,
  output logic          irq_o
);
  logic               slv_evt, to_evt, unc_evt, err_any, err_multi;
  logic [AW-1:0]      fl_addr, sel_addr;
  logic               fl_we, sel_we;
  logic [MW-1:0]      fl_mid, sel_mid;
  bec_pkg::err_kind_e sel_kind;

  assign unc_evt = start_i && !hit_i;

  bec_tracker #(.AW(AW), .MW(MW), .TW(TW)) u_trk (
    .clk_i, .rst_ni, .start_i, .hit_i, .addr_i, .we_i, .mid_i,
    .ready_i, .err_ack_i, .tout_i,
    .slv_evt_o(slv_evt), .to_evt_o(to_evt),
    .fl_addr_o(fl_addr), .fl_we_o(fl_we), .fl_mid_o(fl_mid)
  );

  bec_classify #(.AW(AW), .MW(MW)) u_cls (
    .slv_evt_i(slv_evt), .to_evt_i(to_evt), .unc_evt_i(unc_evt),
    .fl_addr_i(fl_addr), .fl_we_i(fl_we), .fl_mid_i(fl_mid),
    .addr_i, .we_i, .mid_i,
    .any_o(err_any), .multi_o(err_multi), .kind_o(sel_kind),
    .addr_o(sel_addr), .we_o(sel_we), .mid_o(sel_mid)
  );

  bec_capture #(.AW(AW), .DW(DW), .MW(MW)) u_cap (
    .clk_i, .rst_ni,
    .any_i(err_any), .multi_i(err_multi), .kind_i(sel_kind),
    .addr_i(sel_addr), .data_i, .we_i(sel_we), .mid_i(sel_mid),
    .irq_en_i, .clear_i,
    .cap_addr_o, .cap_data_o, .cap_we_o, .cap_mid_o, .cap_kind_o,
    .cap_valid_o, .cap_ovf_o, .irq_o
  );
endmodule

// File: rtl/bec_checker.sv
module bec_checker #(
  parameter int AW = 32,
  parameter int TW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          clear_i,
  input logic          irq_en_i,
  input logic [TW-1:0] tout_i,
  input logic          err_any,
  input logic          to_evt,
  input logic [AW-1:0] cap_addr_o,
  input logic [1:0]    cap_kind_o,
  input logic          cap_valid_o,
  input logic          cap_ovf_o,
  input logic          irq_o
);
  a_r2_fault_sets_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_any |=> cap_valid_o);
  a_r5_zero_limit_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tout_i == '0) |-> !to_evt);
  a_r7_fields_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_valid_o && !clear_i |=> $stable(cap_addr_o) && $stable(cap_kind_o));
  a_r7_overflow_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_valid_o && !clear_i && err_any |=> cap_ovf_o);
  a_r7_overflow_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_ovf_o |-> cap_valid_o);
  a_r8_clear_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i && !err_any |=> !cap_valid_o && !cap_ovf_o);
  a_r9_irq_with_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> cap_valid_o && $past(irq_en_i));
  a_r9_irq_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
endmodule

bind bus_err_capture bec_checker #(.AW(AW), .TW(TW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear_i), .irq_en_i(irq_en_i),
  .tout_i(tout_i), .err_any(err_any), .to_evt(to_evt),
  .cap_addr_o(cap_addr_o), .cap_kind_o(cap_kind_o), .cap_valid_o(cap_valid_o),
  .cap_ovf_o(cap_ovf_o), .irq_o(irq_o)
);

// File: tb/tb_bus_err_capture.sv
module tb_bus_err_capture;
  localparam int AW = 32, DW = 32, MW = 4, TW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, we = 0, hit = 0, ready = 0, err_ack = 0, irq_en = 0, clear = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic [MW-1:0] mid = '0;
  logic [TW-1:0] tout = '0;
  logic [AW-1:0] c_addr;
  logic [DW-1:0] c_data;
  logic c_we, c_valid, c_ovf, irq;
  logic [MW-1:0] c_mid;
  logic [1:0] c_kind;

  always #10 clk = ~clk;

  bus_err_capture #(.AW(AW), .DW(DW), .MW(MW), .TW(TW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .addr_i(addr), .data_i(data),
    .we_i(we), .mid_i(mid), .hit_i(hit), .ready_i(ready), .err_ack_i(err_ack),
    .tout_i(tout), .irq_en_i(irq_en), .clear_i(clear),
    .cap_addr_o(c_addr), .cap_data_o(c_data), .cap_we_o(c_we), .cap_mid_o(c_mid),
    .cap_kind_o(c_kind), .cap_valid_o(c_valid), .cap_ovf_o(c_ovf), .irq_o(irq));

  int checks = 0, errors = 0;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h @%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  bit m_busy; int m_cnt;
  logic [AW-1:0] m_faddr; bit m_fwe; logic [MW-1:0] m_fmid;
  logic [AW-1:0] m_addr; logic [DW-1:0] m_data; bit m_we; logic [MW-1:0] m_mid;
  int m_kind; bit m_valid, m_ovf, m_irq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_cnt = 0; m_faddr = '0; m_fwe = 0; m_fmid = '0;
      m_addr = '0; m_data = '0; m_we = 0; m_mid = '0;
      m_kind = 0; m_valid = 0; m_ovf = 0; m_irq = 0;
    end else begin
      bit s, t, u, held; int n;
      s = m_busy && err_ack;
      t = m_busy && !ready && !err_ack && tout != 0 && (m_cnt + 1 == int'(tout));
      u = start && !hit;
      n = int'(s) + int'(t) + int'(u);
      held = m_valid && !clear;
      m_irq = 0;
      if (n > 0 && !held) begin
        m_kind = s ? 1 : (t ? 3 : 2);
        if (s || t) begin m_addr = m_faddr; m_we = m_fwe; m_mid = m_fmid; end
        else begin m_addr = addr; m_we = we; m_mid = mid; end
        m_data = data; m_valid = 1; m_ovf = (n > 1); m_irq = irq_en;
      end else if (clear) begin
        m_valid = 0; m_ovf = 0;
      end else if (n > 0) m_ovf = 1;
      if (start && hit) begin
        m_busy = 1; m_cnt = 0; m_faddr = addr; m_fwe = we; m_fmid = mid;
      end else if (m_busy && (ready || err_ack || t)) m_busy = 0;
      else if (m_busy) m_cnt++;
    end
  end

  bit run_cmp = 0;
  always @(negedge clk) if (run_cmp) begin
    chk("R8 valid", c_valid, m_valid);
    chk("R7 overflow", c_ovf, m_ovf);
    chk("R9 irq", irq, m_irq);
    chk("R10 kind", c_kind, m_kind);
    chk("R6 addr", c_addr, m_addr);
    chk("R6 data", c_data, m_data);
    chk("R6 we", c_we, m_we);
    chk("R6 mid", c_mid, m_mid);
  end

  task automatic cyc(); @(negedge clk);
    start = 0; hit = 0; ready = 0; err_ack = 0; clear = 0;
  endtask
  task automatic go(input logic [AW-1:0] a, input bit h, input bit w, input logic [MW-1:0] m);
    cyc(); start = 1; hit = h; addr = a; we = w; mid = m; data = $urandom;
  endtask
  task automatic do_clear(); cyc(); clear = 1; endtask

  bit done = 0;
  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #35 rst_n = 1;
    @(negedge clk);
    chk("R1 valid", c_valid, 0); chk("R1 ovf", c_ovf, 0); chk("R1 irq", irq, 0);
    chk("R1 kind", c_kind, 0); chk("R1 addr", c_addr, 0);
    run_cmp = 1;
    tout = 16'd4; irq_en = 1;

    // R11: ready completes, no capture
    go(32'h1000_0040, 1, 1, 4'd3); cyc(); cyc(); ready = 1; cyc(); cyc();
    chk("R11 no capture", c_valid, 0);

    // R2: slave error
    go(32'hA5A5_0010, 1, 0, 4'd5); cyc(); err_ack = 1; data = 32'hDEAD_BEEF; cyc();
    chk("R2 valid", c_valid, 1); chk("R2 kind", c_kind, 1);
    chk("R6 addr", c_addr, 32'hA5A5_0010); chk("R6 data", c_data, 32'hDEAD_BEEF);
    chk("R9 irq pulse", irq, 1);
    // R7: later fault only overflows
    go(32'h0BAD_0000, 0, 1, 4'd1); cyc();
    chk("R7 ovf", c_ovf, 1); chk("R7 addr kept", c_addr, 32'hA5A5_0010);

    // R3: unclaimed
    do_clear(); go(32'h7777_1234, 0, 1, 4'd9); cyc();
    chk("R3 kind", c_kind, 2); chk("R3 addr", c_addr, 32'h7777_1234); chk("R3 mid", c_mid, 9);

    // R4: timeout on the Nth cycle
    do_clear(); go(32'h4000_0000, 1, 0, 4'd2);
    cyc(); cyc(); cyc(); cyc();
    chk("R4 not early", c_valid, 0);
    cyc();
    chk("R4 valid", c_valid, 1); chk("R4 kind", c_kind, 3); chk("R4 addr", c_addr, 32'h4000_0000);
    cyc(); cyc();

    // R4: ready in the last allowed cycle wins
    do_clear(); go(32'h4000_0004, 1, 0, 4'd2); cyc(); cyc(); cyc(); cyc(); ready = 1; cyc(); cyc();
    chk("R4 ready in time", c_valid, 0);

    // R5: zero limit
    tout = 0; go(32'h5000_0000, 1, 1, 4'd6);
    repeat (25) cyc();
    chk("R5 no timeout", c_valid, 0);
    ready = 1; cyc(); tout = 16'd4;

    // R9: enable low suppresses irq
    irq_en = 0; go(32'h6000_0000, 0, 0, 4'd1); cyc();
    chk("R9 valid", c_valid, 1); chk("R9 no irq", irq, 0);
    irq_en = 1;

    // R10: simultaneous slave error and unclaimed start
    do_clear(); go(32'h8000_0000, 1, 0, 4'd4); cyc();
    err_ack = 1; start = 1; hit = 0; addr = 32'h9000_0000; cyc();
    chk("R10 kind", c_kind, 1); chk("R10 addr", c_addr, 32'h8000_0000); chk("R10 ovf", c_ovf, 1);

    // R8: clear plus fault in same cycle
    cyc(); clear = 1; start = 1; hit = 0; addr = 32'hC1EA_0000; cyc();
    chk("R8 fresh capture", c_addr, 32'hC1EA_0000); chk("R8 ovf", c_ovf, 0);
    do_clear(); cyc();
    chk("R8 cleared", c_valid, 0);

    // mixed random traffic against the reference
    for (int i = 0; i < 3000; i++) begin
      cyc();
      if (i % 200 == 0) tout = 16'($urandom_range(0, 6));
      irq_en = $urandom_range(0, 1);
      start = ($urandom_range(0, 5) == 0); hit = ($urandom_range(0, 3) != 0);
      addr = $urandom; data = $urandom; we = $urandom_range(0, 1); mid = 4'($urandom);
      ready = ($urandom_range(0, 4) == 0); err_ack = ($urandom_range(0, 9) == 0);
      clear = ($urandom_range(0, 7) == 0);
    end
    cyc(); cyc();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule